// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Phase Decoder

This block sits on the target side of a 64-bit bus in which the address and the data share one set of lines, and the command and byte enables share another. It watches every bus clock and works out which phase the bus is in. The clock that carries the frame-start strobe is an address phase. It is followed by any number of data phases, each marked by the data-valid strobe. The block captures the full 64-bit address and the 4-bit bus command, and reports them as one address result. After that, each accepted data phase comes out as one beat: the 64-bit data word and an active-high mask of the byte lanes that carry meaningful data.

A transaction can also open with the dual-address form, which spreads a 64-bit address over two clocks. In the first clock the low command nibble holds a fixed marker code and the real command sits on the high nibble. In the second clock the upper address half arrives on the low data lanes. The block joins the two halves and raises a flag that marks the address as dual-address.

The block also checks even parity over the low 32 data lanes and the low command nibble. The parity bit for a clock arrives one clock after the lanes it covers. The outputs are strobes with no ready input. The bus cannot be stalled, so any logic that uses the address or beat results must take each strobe in the cycle it is high.

Top module: `bus_phase_decoder`

## Requirements
- R1: One clock after a frame-start clock whose `cbe_n[3:0]` is not 4'b1101, `addr_valid` is 1 for that one cycle. In the same cycle `addr` equals that clock's `ad`, `cmd` equals that clock's `cbe_n[3:0]`, and `dac` is 0.
- R2: A frame-start clock with `cbe_n[3:0]` equal to 4'b1101 gives no `addr_valid` in the next cycle. The clock after it is the second address clock. One clock after that second clock, `addr_valid` is 1, `addr` is {second clock `ad[31:0]`, first clock `ad[31:0]`}, `cmd` is the first clock's `cbe_n[7:4]`, and `dac` is 1.
- R3: Each clock in the data phase with `data_valid` high, including back-to-back clocks in a burst, makes `beat_valid` high one clock later. In that cycle `beat_data` equals that clock's `ad`, and bit n of `beat_lanes` is the inverse of `cbe_n[n]`, where lane 0 is `ad[7:0]` and lane 7 is `ad[63:56]`. A data-phase clock with `data_valid` low gives no beat.
- R4: A data-phase clock with `data_valid` high and `cbe_n` equal to 8'hFF still gives a beat, with `beat_lanes` equal to 8'h00.
- R5: `data_valid` has no effect, and no beat follows, when it is high on a frame-start clock, on the second clock of a dual-address cycle, or while no transaction has begun since reset.
- R6: A frame-start clock always starts a new address phase, even in the middle of a dual-address cycle or a data burst. The decode that was in progress is dropped.
- R7: On a covered clock (an address clock, or a data-phase clock with `data_valid` high), `par_err` is high for one cycle, one clock after `par` is sampled on the following clock, exactly when the XOR of that clock's `ad[31:0]`, its `cbe_n[3:0]` and the later `par` is 1.
- R8: No `par_err` is raised for clocks that are not covered: idle clocks, and data-phase clocks with `data_valid` low.
- R9: A synchronous `rst` clears `addr_valid`, `addr`, `cmd`, `dac`, `beat_valid`, `beat_data`, `beat_lanes` and `par_err` to 0, and returns the decoder to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_start | input | 1 | Marks the first address clock of a transaction |
| data_valid | input | 1 | Marks a data-phase clock that carries a beat |
| ad | input | 64 | Shared address/data lines |
| cbe_n | input | 8 | Shared command / active-low byte enable lines |
| par | input | 1 | Even parity for the previous clock's low lanes |
| addr_valid | output | 1 | One-cycle strobe: address and command captured |
| addr | output | 64 | Captured byte address |
| cmd | output | 4 | Captured bus command |
| dac | output | 1 | Captured address came from a dual-address cycle |
| beat_valid | output | 1 | One-cycle strobe: data beat present |
| beat_data | output | 64 | Beat data word |
| beat_lanes | output | 8 | Active-high byte lane mask of the beat |
| par_err | output | 1 | One-cycle parity error pulse |

## Verification
The parity checker and the phase decoder act in the same cycle. A parity error for one clock is reported in the cycle that the next address result or data beat is presented. The bench provokes this by inverting `par` on the clock that follows an address clock or a beat. It then checks that `par_err` and the matching `addr_valid` or `beat_valid` are both high, with the captured values intact. A frame-start clock that also drives `data_valid` pits R5 against R3, and the bench judges it by the absence of `beat_valid` next to a correct `addr_valid`.

// File: rtl/bpd_pkg.sv
package bpd_pkg;
  localparam int CMD_W = 4;
  localparam logic [CMD_W-1:0] DUAL_ADDR_CODE = 4'b1101;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ADDR2 = 2'd1,
    PH_DATA  = 2'd2
  } phase_t;
endpackage

// File: rtl/bpd_addr_phase.sv
module bpd_addr_phase
  import bpd_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int LANES = DATA_W / 8,
  localparam int HALF  = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic [DATA_W-1:0] ad,
  input  logic [LANES-1:0]  cbe_n,
  output phase_t            phase,
  output logic              addr_clk,
  output logic              addr_valid,
  output logic [DATA_W-1:0] addr,
  output logic [CMD_W-1:0]  cmd,
  output logic              dac
);
  logic [HALF-1:0]  lo_half_q;
  logic [CMD_W-1:0] pend_cmd_q;
  logic             is_dual;

  assign is_dual  = (cbe_n[CMD_W-1:0] == DUAL_ADDR_CODE);
  assign addr_clk = frame_start | (phase == PH_ADDR2);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      addr_valid <= 1'b0;
      addr       <= '0;
      cmd        <= '0;
      dac        <= 1'b0;
      lo_half_q  <= '0;
      pend_cmd_q <= '0;
    end else begin
      addr_valid <= 1'b0;
      if (frame_start) begin
        if (is_dual) begin
          lo_half_q  <= ad[HALF-1:0];
          pend_cmd_q <= cbe_n[2*CMD_W-1:CMD_W];
          phase      <= PH_ADDR2;
        end else begin
          addr       <= ad;
          cmd        <= cbe_n[CMD_W-1:0];
          dac        <= 1'b0;
          addr_valid <= 1'b1;
          phase      <= PH_DATA;
        end
      end else if (phase == PH_ADDR2) begin
        addr       <= {ad[HALF-1:0], lo_half_q};
        cmd        <= pend_cmd_q;
        dac        <= 1'b1;
        addr_valid <= 1'b1;
        phase      <= PH_DATA;
      end
    end
  end
endmodule

// File: rtl/bpd_beat_capture.sv
module bpd_beat_capture #(
  parameter int DATA_W = 64,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [DATA_W-1:0] ad,
  input  logic [LANES-1:0]  cbe_n,
  output logic              beat_valid,
  output logic [DATA_W-1:0] beat_data,
  output logic [LANES-1:0]  beat_lanes
);
  logic [LANES-1:0] lane_on;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_on[i] = ~cbe_n[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_valid <= 1'b0;
      beat_data  <= '0;
      beat_lanes <= '0;
    end else begin
      beat_valid <= take;
      if (take) begin
        beat_data  <= ad;
        beat_lanes <= lane_on;
      end
    end
  end
endmodule

// File: rtl/bpd_parity_chk.sv
module bpd_parity_chk #(
  parameter int COV_W = 36
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             covered,
  input  logic [COV_W-1:0] lanes,
  input  logic             par,
  output logic             par_err
);
  logic [COV_W-1:0] held_q;
  logic             armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q  <= '0;
      armed_q <= 1'b0;
      par_err <= 1'b0;
    end else begin
      held_q  <= lanes;
      armed_q <= covered;
      par_err <= armed_q & ((^held_q) ^ par);
    end
  end
endmodule

// File: rtl/bus_phase_decoder.sv
module bus_phase_decoder
  import bpd_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int LANES = DATA_W / 8,
  localparam int HALF  = DATA_W / 2,
  localparam int COV_W = HALF + CMD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              data_valid,
  input  logic [DATA_W-1:0] ad,
  input  logic [LANES-1:0]  cbe_n,
  input  logic              par,
  output logic              addr_valid,
  output logic [DATA_W-1:0] addr,
  output logic [CMD_W-1:0]  cmd,
  output logic              dac,
  output logic              beat_valid,
  output logic [DATA_W-1:0] beat_data,
  output logic [LANES-1:0]  beat_lanes,
  output logic              par_err
);
  phase_t phase;
  logic   addr_clk;
  logic   take_beat;

  assign take_beat = data_valid & ~frame_start & (phase == PH_DATA);

  bpd_addr_phase #(.DATA_W(DATA_W)) u_addr (
    .clk(clk), .rst(rst), .frame_start(frame_start), .ad(ad), .cbe_n(cbe_n),
    .phase(phase), .addr_clk(addr_clk), .addr_valid(addr_valid),
    .addr(addr), .cmd(cmd), .dac(dac)
  );

  bpd_beat_capture #(.DATA_W(DATA_W)) u_beat (
    .clk(clk), .rst(rst), .take(take_beat), .ad(ad), .cbe_n(cbe_n),
    .beat_valid(beat_valid), .beat_data(beat_data), .beat_lanes(beat_lanes)
  );

  bpd_parity_chk #(.COV_W(COV_W)) u_par (
    .clk(clk), .rst(rst), .covered(addr_clk | take_beat),
    .lanes({ad[HALF-1:0], cbe_n[CMD_W-1:0]}), .par(par), .par_err(par_err)
  );
endmodule

// File: rtl/bpd_checker.sv
module bpd_checker
  import bpd_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int LANES = DATA_W / 8,
  localparam int HALF  = DATA_W / 2
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_start,
  input logic              data_valid,
  input logic [DATA_W-1:0] ad,
  input logic [LANES-1:0]  cbe_n,
  input logic              par,
  input logic              addr_valid,
  input logic [DATA_W-1:0] addr,
  input logic [CMD_W-1:0]  cmd,
  input logic              dac,
  input logic              beat_valid,
  input logic [DATA_W-1:0] beat_data,
  input logic [LANES-1:0]  beat_lanes,
  input logic              par_err
);
  p_single_addr_r1: assert property (@(posedge clk) disable iff (rst)
    (frame_start && cbe_n[CMD_W-1:0] != DUAL_ADDR_CODE) |=>
      (addr_valid && !dac && addr == $past(ad) && cmd == $past(cbe_n[CMD_W-1:0])));

  p_dual_wait_r2: assert property (@(posedge clk) disable iff (rst)
    (frame_start && cbe_n[CMD_W-1:0] == DUAL_ADDR_CODE) |=> !addr_valid);

  p_dual_done_r2: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && dac) |->
      ($past(frame_start, 2) && $past(cbe_n[CMD_W-1:0], 2) == DUAL_ADDR_CODE &&
       addr[HALF-1:0] == $past(ad[HALF-1:0], 2) && addr[DATA_W-1:HALF] == $past(ad[HALF-1:0])));

  p_beat_r3: assert property (@(posedge clk) disable iff (rst)
    beat_valid |->
      ($past(data_valid) && !$past(frame_start) &&
       beat_data == $past(ad) && beat_lanes == ~$past(cbe_n)));

  p_no_beat_on_frame_r5: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !beat_valid);

  p_parity_r7: assert property (@(posedge clk) disable iff (rst)
    par_err |-> ($past(par) ^ (^$past(ad[HALF-1:0], 2)) ^ (^$past(cbe_n[CMD_W-1:0], 2))));
endmodule

bind bus_phase_decoder bpd_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_bus_phase_decoder.sv
module tb_bus_phase_decoder;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_start = 1'b0;
  logic        data_valid = 1'b0;
  logic [63:0] ad = '0;
  logic [7:0]  cbe_n = 8'hFF;
  logic        par = 1'b0;
  logic        addr_valid, dac, beat_valid, par_err;
  logic [63:0] addr, beat_data;
  logic [3:0]  cmd;
  logic [7:0]  beat_lanes;

  int nchk = 0;
  int nerr = 0;
  logic [35:0] prev_cov = '0;

  always #(CLK_P/2) clk = ~clk;

  bus_phase_decoder dut (
    .clk(clk), .rst(rst), .frame_start(frame_start), .data_valid(data_valid),
    .ad(ad), .cbe_n(cbe_n), .par(par), .addr_valid(addr_valid), .addr(addr),
    .cmd(cmd), .dac(dac), .beat_valid(beat_valid), .beat_data(beat_data),
    .beat_lanes(beat_lanes), .par_err(par_err)
  );

  typedef struct packed {
    logic [63:0] a;
    logic [3:0]  c;
    logic [63:0] d;
    logic [7:0]  be;
    logic [7:0]  lanes;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{64'h0123_4567_89AB_CDEF, 4'h6, 64'hDEAD_BEEF_0000_1111, 8'h00, 8'hFF},
    '{64'hFFFF_0000_1234_5678, 4'h7, 64'h5555_AAAA_5555_AAAA, 8'hF0, 8'h0F},
    '{64'h0000_0000_0000_0040, 4'h2, 64'h0000_0000_0000_0001, 8'h5A, 8'hA5},
    '{64'h8000_0000_0000_0000, 4'hC, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFE, 8'h01}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One bus clock; par carries the parity of the previous clock's lanes, optionally inverted.
  task automatic cyc(input logic fs, input logic dv, input logic [63:0] a,
                     input logic [7:0] be, input logic flip);
    frame_start = fs;
    data_valid  = dv;
    ad          = a;
    cbe_n       = be;
    par         = (^prev_cov) ^ flip;
    @(posedge clk);
    #1;
    prev_cov = {a[31:0], be[3:0]};
  endtask

  initial begin
    #(CLK_P * 200000);
    nerr++;
    nchk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #1;
    rst = 1'b1;
    cyc(0, 0, '0, 8'hFF, 0);
    cyc(0, 0, '0, 8'hFF, 0);
    check("R9 addr_valid", addr_valid, 0);
    check("R9 beat_valid", beat_valid, 0);
    check("R9 par_err", par_err, 0);
    check("R9 addr", addr, 0);
    check("R9 dac", dac, 0);
    rst = 1'b0;

    // R5 data_valid before any transaction
    cyc(0, 1, 64'h1234, 8'h00, 0);
    check("R5 idle beat", beat_valid, 0);
    // R8 idle clock not covered: inverted par raises nothing
    cyc(0, 0, 64'h1, 8'hFF, 1);
    check("R8 idle parity", par_err, 0);

    // Table walk: single-address transactions with one beat each (R1, R3, R7)
    for (int i = 0; i < 4; i++) begin
      cyc(1, 0, VECS[i].a, {4'h0, VECS[i].c}, 0);
      check("R1 addr_valid", addr_valid, 1);
      check("R1 addr", addr, VECS[i].a);
      check("R1 cmd", cmd, VECS[i].c);
      check("R1 dac", dac, 0);
      cyc(0, 1, VECS[i].d, VECS[i].be, 0);
      check("R3 beat_valid", beat_valid, 1);
      check("R3 beat_data", beat_data, VECS[i].d);
      check("R3 beat_lanes", beat_lanes, VECS[i].lanes);
      check("R7 clean parity", par_err, 0);
    end

    // Burst with a gap and an all-disabled beat (R3, R4)
    cyc(1, 0, 64'h100, 8'h03, 0);
    cyc(0, 1, 64'hA1, 8'h00, 0);
    check("R3 burst beat0", beat_data, 64'hA1);
    cyc(0, 1, 64'hA2, 8'h0F, 0);
    check("R3 burst beat1 lanes", beat_lanes, 8'hF0);
    cyc(0, 0, 64'hA3, 8'hFF, 0);
    check("R3 gap no beat", beat_valid, 0);
    cyc(0, 1, 64'hA4, 8'hFF, 0);
    check("R4 empty beat valid", beat_valid, 1);
    check("R4 empty beat lanes", beat_lanes, 0);
    // R8 data-phase clock with data_valid low is not covered
    cyc(0, 0, 64'h7, 8'hFF, 0);
    cyc(0, 0, 64'h8, 8'hFF, 1);
    check("R8 idle data clock parity", par_err, 0);

    // Dual-address cycle (R2, R5)
    cyc(1, 0, {32'hAAAA_BBBB, 32'h1111_2222}, {4'h7, 4'hD}, 0);
    check("R2 no addr after first clock", addr_valid, 0);
    cyc(0, 1, {32'h9999_9999, 32'h0000_00FE}, 8'h07, 0);
    check("R2 addr_valid", addr_valid, 1);
    check("R2 addr", addr, 64'h0000_00FE_1111_2222);
    check("R2 cmd", cmd, 4'h7);
    check("R2 dac", dac, 1);
    check("R5 no beat on second address clock", beat_valid, 0);
    cyc(0, 1, 64'hCAFE, 8'h00, 0);
    check("R2 beat after dual", beat_data, 64'hCAFE);

    // Frame start with data_valid (R5) and parity error on address clock (R7)
    cyc(1, 1, 64'h55, 8'h06, 0);
    check("R5 no beat on frame clock", beat_valid, 0);
    check("R1 addr on frame+dv", addr, 64'h55);
    cyc(0, 1, 64'h66, 8'hF0, 1);
    check("R7 par_err with beat", par_err, 1);
    check("R7 beat alongside error", beat_data, 64'h66);
    cyc(0, 0, 64'h0, 8'hFF, 0);
    check("R7 pulse one cycle", par_err, 0);

    // Abort dual cycle with new single frame (R6)
    cyc(1, 0, {32'h0, 32'hDDDD_0000}, {4'h3, 4'hD}, 0);
    cyc(1, 0, 64'h4444_0000_0000_0010, 8'h0A, 0);
    check("R6 restart addr", addr, 64'h4444_0000_0000_0010);
    check("R6 restart dac", dac, 0);
    check("R6 restart cmd", cmd, 4'hA);

    // Abort burst with dual frame (R6)
    cyc(0, 1, 64'h77, 8'h00, 0);
    cyc(1, 0, {32'h0, 32'h0000_0ABC}, {4'hB, 4'hD}, 0);
    cyc(0, 1, {32'h0, 32'h0000_0001}, 8'h0B, 0);
    check("R6 dual after burst", addr, 64'h0000_0001_0000_0ABC);
    check("R6 no beat second clock", beat_valid, 0);

    // Reset clears dac (R9)
    rst = 1'b1;
    cyc(0, 0, '0, 8'hFF, 0);
    check("R9 dac cleared", dac, 0);
    check("R9 addr cleared", addr, 0);
    rst = 1'b0;

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule